// File: doc/BRIEF.md
# Paged Two-Wire Management Register Slave

This block is the management-bus target of a pluggable optical module. A host reaches a 256-byte register window over a two-wire (I2C-compatible) bus. The lower 128 bytes are fixed. The upper 128 bytes are banked: the byte held at lower address 127 chooses which upper page appears at addresses 128 to 255. An active-low select input gates the whole bus. While select is high the slave ignores all traffic and never drives the data line.

The host writes by sending the write address, a one-byte offset and then data bytes, each landing at the pointer and advancing it. To read, the host first sets the offset with a write header. It then issues a repeated start with the read address and clocks bytes out, acknowledging each one it wants to continue with. A not-acknowledge ends the read. Every byte fetched for transmission raises a one-cycle read strobe, and every byte stored raises a one-cycle write strobe. Both strobes carry the address and the current page, so that neighbouring flag and channel-control logic can clear latched flags on read or react to writes.

The bus lines are first resampled into the system clock, and all protocol decisions are made on the resulting edge events. The data output is open-drain in spirit: the single output only requests a low on the line. The FSM has seven states:

- ST_IDLE: waits for a start.
- ST_ADDR: shifts in the address byte.
- ST_ADDR_ACK: drives the acknowledge for a matching address.
- ST_WR_BYTE: shifts in an offset or data byte.
- ST_WR_ACK: drives the acknowledge of a received byte.
- ST_RD_BYTE: shifts out a byte, MSB first.
- ST_RD_ACK: samples the host's acknowledge.

Transitions:

- Start, from any state, goes to ST_ADDR.
- Stop, or select high, from any state, goes to ST_IDLE.
- In ST_ADDR, the eighth clock fall goes to ST_ADDR_ACK if the address matches, else to ST_IDLE.
- In ST_ADDR_ACK, the next fall goes to ST_RD_BYTE if the read bit is set, else to ST_WR_BYTE.
- In ST_WR_BYTE, the eighth fall goes to ST_WR_ACK.
- In ST_WR_ACK, the next fall goes back to ST_WR_BYTE.
- In ST_RD_BYTE, the eighth fall goes to ST_RD_ACK.
- In ST_RD_ACK, the next fall goes to ST_RD_BYTE if the host acknowledged, else to ST_IDLE.

Top module: `mgmt_twi_slave`

## Requirements
- R1: After reset the data-line pull request is low, both strobes are low, every stored byte reads 00h and the page byte (address 127) is 0.
- R2: The slave acknowledges only the 7-bit address 1010000 (A0h write, A1h read). Any other address gets no acknowledge, and the slave stays silent until the next start.
- R3: While the active-low select input is high, the slave never pulls the data line and acknowledges nothing. Raising select in the middle of a transfer returns the slave to idle and releases the line.
- R4: In a write, the first byte after the address loads the pointer. Each following byte is stored at the pointer and acknowledged, with a one-cycle write strobe carrying that address and data.
- R5: Address 127 is the page byte. Addresses 128 to 255 access the upper page it names, and only a write to address 127 changes it.
- R6: The pointer advances by one after each stored or fetched byte, wrapping from 127 to 0 and from 255 to 128.
- R7: With the page byte naming a page at or above NUM_PAGES, upper addresses read 00h. Writes to them are acknowledged and change nothing.
- R8: Address 2 reads with bit 0 equal to the not-ready input, bit 1 equal to the interrupt-line level input, and bits 7..2 zero. Writes to address 2 are ignored.
- R9: In a read, a host acknowledge fetches the next byte and a not-acknowledge ends the transfer. Each fetched byte gives one read strobe.
- R10: A repeated start in the middle of a transfer restarts the address phase and keeps the pointer, so a write header followed by a read returns data from the chosen offset.
- R11: Bytes are sent MSB first. A 0 bit or an acknowledge is a pull request of 1, and a 1 bit is a released line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low module select |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 requests the data line be pulled low |
| not_ready_i | input | 1 | Data-not-ready status, shown at address 2 bit 0 |
| int_n_i | input | 1 | Interrupt line level, shown at address 2 bit 1 |
| reg_rd_o | output | 1 | One-cycle strobe per fetched byte |
| reg_wr_o | output | 1 | One-cycle strobe per stored byte |
| reg_addr_o | output | 8 | Address of the strobed access |
| reg_page_o | output | 8 | Current page byte |
| reg_wdata_o | output | 8 | Data of the strobed write |

## Verification
The bench builds the block with its defaults: device address 50h, two implemented upper pages and two resampling stages. With two pages, page 1 is a real bank distinct from page 0, while page 5 reaches the unimplemented-page path for both reads and writes. A behavioural model of the window and pointer predicts every read byte, and the bench checks on every clock that the line is never pulled while select has been high.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } twi_state_e;

    localparam int PAGE_BYTES = 128;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sel_n_i,
    output logic sda_s_o,
    output logic sel_n_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_p, sda_p, sel_p;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            sel_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            sel_p <= {sel_p[STAGES-2:0], sel_n_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s      = scl_p[STAGES-1];
    assign sda_s      = sda_p[STAGES-1];
    assign sda_s_o    = sda_s;
    assign sel_n_s_o  = sel_p[STAGES-1];
    assign scl_rise_o = scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s & scl_q;
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_paged_mem.sv
module twi_paged_mem import twi_pkg::*; #(
    parameter int         NUM_PAGES    = 2,
    parameter logic [7:0] STATUS_ADDR  = 8'd2,
    parameter logic [6:0] PAGE_SEL_IDX = 7'd127
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr_i,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    input  logic       not_ready_i,
    input  logic       int_n_i,
    output logic [7:0] rdata_o,
    output logic [7:0] page_o
);

    localparam int PB       = $clog2(NUM_PAGES);
    localparam int UPW      = PB + 7;
    localparam int UP_DEPTH = NUM_PAGES * PAGE_BYTES;

    logic [7:0]     lo [PAGE_BYTES];
    logic [7:0]     up [UP_DEPTH];
    logic [7:0]     page_q;
    logic           page_ok;
    logic [UPW-1:0] up_idx;

    assign page_q  = lo[PAGE_SEL_IDX];
    assign page_ok = (int'(page_q) < NUM_PAGES);
    assign up_idx  = {page_q[PB-1:0], addr_i[6:0]};
    assign page_o  = page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) lo[i] <= '0;
            for (int j = 0; j < UP_DEPTH; j++)   up[j] <= '0;
        end else if (we_i && addr_i != STATUS_ADDR) begin
            if (!addr_i[7])   lo[addr_i[6:0]] <= wdata_i;
            else if (page_ok) up[up_idx]      <= wdata_i;
        end
    end

    always_comb begin
        if (addr_i == STATUS_ADDR) rdata_o = {6'b0, int_n_i, not_ready_i};
        else if (!addr_i[7])       rdata_o = lo[addr_i[6:0]];
        else if (page_ok)          rdata_o = up[up_idx];
        else                       rdata_o = 8'h00;
    end

    // R5: the page byte moves only when address 127 is written
    a_r5_page_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == {1'b0, PAGE_SEL_IDX}) |=> $stable(page_q))
        else $error("page byte changed without a write to it");

endmodule

// File: rtl/twi_bus_fsm.sv
module twi_bus_fsm import twi_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n_s_i,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] rdata_i,
    output logic       pull_o,
    output logic [7:0] ptr_o,
    output logic       we_o,
    output logic [7:0] wdata_o,
    output logic       rd_o
);

    twi_state_e state, state_n;
    logic [3:0] cnt, cnt_n;
    logic [7:0] sh, sh_n;
    logic [7:0] tx, tx_n;
    logic [7:0] ptr, ptr_n;
    logic       rw, rw_n;
    logic       first, first_n;
    logic       mack, mack_n;
    logic       adv;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sh_n    = sh;
        tx_n    = tx;
        ptr_n   = ptr;
        rw_n    = rw;
        first_n = first;
        mack_n  = mack;
        we_o    = 1'b0;
        rd_o    = 1'b0;
        adv     = 1'b0;
        if (sel_n_s_i) begin
            state_n = ST_IDLE;
        end else if (start_i) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
        end else if (stop_i) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        sh_n  = {sh[6:0], sda_s_i};
                        cnt_n = cnt + 4'd1;
                    end else if (scl_fall_i && cnt == 4'd8) begin
                        if (sh[7:1] == DEV_ADDR) begin
                            state_n = ST_ADDR_ACK;
                            rw_n    = sh[0];
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        cnt_n = '0;
                        if (rw) begin
                            tx_n    = rdata_i;
                            rd_o    = 1'b1;
                            adv     = 1'b1;
                            state_n = ST_RD_BYTE;
                        end else begin
                            first_n = 1'b1;
                            state_n = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise_i) begin
                        sh_n  = {sh[6:0], sda_s_i};
                        cnt_n = cnt + 4'd1;
                    end else if (scl_fall_i && cnt == 4'd8) begin
                        if (first) begin
                            ptr_n   = sh;
                            first_n = 1'b0;
                        end else begin
                            we_o = 1'b1;
                            adv  = 1'b1;
                        end
                        state_n = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        cnt_n   = '0;
                        state_n = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall_i) begin
                        if (cnt == 4'd7) begin
                            state_n = ST_RD_ACK;
                        end else begin
                            tx_n  = {tx[6:0], 1'b0};
                            cnt_n = cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        mack_n = ~sda_s_i;
                    end else if (scl_fall_i) begin
                        if (mack) begin
                            tx_n    = rdata_i;
                            rd_o    = 1'b1;
                            adv     = 1'b1;
                            cnt_n   = '0;
                            state_n = ST_RD_BYTE;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
        if (adv) ptr_n = {ptr[7], ptr[6:0] + 7'd1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            tx    <= 8'hFF;
            ptr   <= '0;
            rw    <= 1'b0;
            first <= 1'b0;
            mack  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            sh    <= sh_n;
            tx    <= tx_n;
            ptr   <= ptr_n;
            rw    <= rw_n;
            first <= first_n;
            mack  <= mack_n;
        end
    end

    always_comb begin
        pull_o  = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                  (state == ST_RD_BYTE && !tx[7]);
        ptr_o   = ptr;
        wdata_o = sh;
    end

    // R2: an address acknowledge follows only a matching address byte
    a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> (sh[7:1] == DEV_ADDR))
        else $error("acknowledged a foreign address");

    // R6: lower-half pointer wraps to 0
    a_r6_lower_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == 8'd127 && !sel_n_s_i) |=> (ptr == 8'd0))
        else $error("lower wrap wrong");

    // R6: upper-half pointer wraps to 128
    a_r6_upper_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == 8'd255 && !sel_n_s_i) |=> (ptr == 8'd128))
        else $error("upper wrap wrong");

endmodule

// File: rtl/mgmt_twi_slave.sv
module mgmt_twi_slave import twi_pkg::*; #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         NUM_PAGES   = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       not_ready_i,
    input  logic       int_n_i,
    output logic       reg_rd_o,
    output logic       reg_wr_o,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_page_o,
    output logic [7:0] reg_wdata_o
);

    logic       sda_s, sel_n_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] ptr, rdata, wdata;
    logic       we, rd, pull;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sel_n_i    (sel_n_i),
        .sda_s_o    (sda_s),
        .sel_n_s_o  (sel_n_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    twi_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_s_i  (sel_n_s),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .rdata_i    (rdata),
        .pull_o     (pull),
        .ptr_o      (ptr),
        .we_o       (we),
        .wdata_o    (wdata),
        .rd_o       (rd)
    );

    twi_paged_mem #(.NUM_PAGES(NUM_PAGES)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (ptr),
        .we_i        (we),
        .wdata_i     (wdata),
        .not_ready_i (not_ready_i),
        .int_n_i     (int_n_i),
        .rdata_o     (rdata),
        .page_o      (reg_page_o)
    );

    assign sda_pull_o  = pull;
    assign reg_rd_o    = rd;
    assign reg_wr_o    = we;
    assign reg_addr_o  = ptr;
    assign reg_wdata_o = wdata;

    // R3: a deselected slave releases the line from the next cycle on
    a_r3_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !sda_pull_o)
        else $error("line pulled while deselected");

endmodule

// File: tb/test_mgmt_twi_slave.sv
module test_mgmt_twi_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NP         = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic not_ready = 1'b0;
    logic int_n = 1'b1;
    logic sda_pull, rd_stb, wr_stb;
    logic [7:0] r_addr, r_page, r_wdata;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_twi_slave i_mgmt_twi_slave (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .not_ready_i(not_ready), .int_n_i(int_n),
        .reg_rd_o(rd_stb), .reg_wr_o(wr_stb), .reg_addr_o(r_addr),
        .reg_page_o(r_page), .reg_wdata_o(r_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int sel_hi = 0;
    int dsel_viol = 0;
    logic [7:0] last_waddr = 8'h00;
    logic [7:0] last_wdata = 8'h00;

    // reference model of the register window
    logic [7:0] m_lo [128];
    logic [7:0] m_up [NP*128];
    logic [7:0] m_ptr = 8'h00;

    function automatic logic [7:0] mrd(input logic [7:0] a);
        if (a == 8'd2) return {6'b0, int_n, not_ready};
        if (a < 8'd128) return m_lo[a[6:0]];
        if (int'(m_lo[127]) < NP) return m_up[int'(m_lo[127]) * 128 + int'(a[6:0])];
        return 8'h00;
    endfunction

    function automatic void mwr(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'd2) return;
        if (a < 8'd128) m_lo[a[6:0]] = d;
        else if (int'(m_lo[127]) < NP) m_up[int'(m_lo[127]) * 128 + int'(a[6:0])] = d;
    endfunction

    function automatic logic [7:0] minc(input logic [7:0] a);
        return {a[7], a[6:0] + 7'd1};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        sel_hi <= sel_n ? sel_hi + 1 : 0;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // per-clock comparison: the line must be free once deselection settled (R3)
    always @(negedge clk) begin
        if (rd_stb) rd_cnt++;
        if (wr_stb) begin
            wr_cnt++;
            last_waddr = r_addr;
            last_wdata = r_wdata;
        end
        if (sel_hi >= 4 && sda_pull) dsel_viol++;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic t_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic t_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic t_recv(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input string tag, input logic [7:0] off, input logic [7:0] d [$]);
        logic ack;
        t_start;
        t_send(8'hA0, ack); chk({tag, " addr ack"}, ack, 1);
        t_send(off, ack);   chk({tag, " offset ack"}, ack, 1);
        m_ptr = off;
        foreach (d[k]) begin
            t_send(d[k], ack); chk({tag, " data ack"}, ack, 1);
            mwr(m_ptr, d[k]);
            m_ptr = minc(m_ptr);
        end
        t_stop;
    endtask

    task automatic do_read(input string tag, input logic [7:0] off, input int n);
        logic ack;
        logic [7:0] b;
        t_start;
        t_send(8'hA0, ack); chk({tag, " addr ack"}, ack, 1);
        t_send(off, ack);   chk({tag, " offset ack"}, ack, 1);
        t_start;
        t_send(8'hA1, ack); chk({tag, " read addr ack"}, ack, 1);
        m_ptr = off;
        for (int i = 0; i < n; i++) begin
            t_recv(i < n - 1, b);
            chk({tag, " data"}, b, mrd(m_ptr));
            m_ptr = minc(m_ptr);
        end
        t_stop;
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int w0, r0;
        for (int i = 0; i < 128; i++) m_lo[i] = 8'h00;
        for (int i = 0; i < NP*128; i++) m_up[i] = 8'h00;
        wq(5);
        // R1 / R11: quiet after reset
        chk("R1 pull after reset", sda_pull, 0);
        chk("R1 strobes after reset", {rd_stb, wr_stb}, 0);
        chk("R1 page after reset", r_page, 0);
        rst_n = 1'b1;
        sel_n = 1'b0;
        wq(8);
        do_read("R1 reset contents", 8'd0, 2);
        do_read("R1 reset contents upper", 8'd200, 1);

        // R4 / R11: write with strobes, then random read (R10, R9)
        w0 = wr_cnt;
        do_write("R4 write", 8'd10, '{8'hA5, 8'h3C});
        chk("R4 write strobes", wr_cnt - w0, 2);
        chk("R4 last strobe addr", last_waddr, 11);
        chk("R4 last strobe data", last_wdata, 8'h3C);
        r0 = rd_cnt;
        do_read("R10 random read", 8'd10, 2);
        chk("R9 read strobes", rd_cnt - r0, 2);

        // R2: foreign address gets no acknowledge
        t_start;
        t_send(8'hA2, ack); chk("R2 foreign addr nack", ack, 0);
        t_send(8'h10, ack); chk("R2 silent after foreign", ack, 0);
        t_stop;

        // R8: status byte
        not_ready = 1'b1; int_n = 1'b0; wq(4);
        do_read("R8 status nr", 8'd2, 1);
        not_ready = 1'b0; int_n = 1'b1; wq(4);
        do_write("R8 status write", 8'd2, '{8'hFF});
        do_read("R8 status after write", 8'd2, 1);

        // R6: lower wrap
        do_write("R6 lower fill", 8'd126, '{8'h11, 8'h00, 8'h33});
        do_read("R6 lower wrap", 8'd126, 3);

        // R5: page banking
        do_write("R5 page1", 8'd127, '{8'h01});
        chk("R5 page out", r_page, 1);
        do_write("R5 page1 data", 8'd200, '{8'h77});
        do_write("R5 page0", 8'd127, '{8'h00});
        do_read("R5 page0 read", 8'd200, 1);
        do_write("R5 back page1", 8'd127, '{8'h01});
        do_read("R5 page1 read", 8'd200, 1);

        // R6: upper wrap on page 0
        do_write("R6 page0 sel", 8'd127, '{8'h00});
        do_write("R6 upper fill", 8'd255, '{8'h44, 8'h55});
        do_read("R6 upper wrap", 8'd255, 2);

        // R7: unimplemented page
        do_write("R7 page0 seed", 8'd130, '{8'h12});
        do_write("R7 page5 sel", 8'd127, '{8'h05});
        do_write("R7 page5 write", 8'd130, '{8'h99});
        do_read("R7 page5 read", 8'd130, 2);
        do_write("R7 page0 back", 8'd127, '{8'h00});
        do_read("R7 page0 untouched", 8'd130, 1);

        // R9: not-acknowledge ends the read, line stays free
        do_read("R9 single", 8'd10, 1);
        chk("R9 line free after nack", sda_pull, 0);

        // R3: deselected slave ignores its own address
        sel_n = 1'b1; wq(8);
        t_start;
        t_send(8'hA0, ack); chk("R3 no ack deselected", ack, 0);
        t_stop;
        sel_n = 1'b0; wq(8);

        // R3: deselect in the middle of a read
        t_start;
        t_send(8'hA0, ack);
        t_send(8'd126, ack);
        t_start;
        t_send(8'hA1, ack); chk("R3 read addr ack", ack, 1);
        sel_n = 1'b1; wq(8);
        chk("R3 released mid transfer", sda_pull, 0);
        t_recv(1'b0, b);
        chk("R3 no data while deselected", b, 8'hFF);
        t_stop;
        sel_n = 1'b0; wq(8);
        do_read("R3 recovered", 8'd10, 2);

        chk("R3 per-clock deselect violations", dsel_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule